// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Byte Service Key

This block watches over software running on the chip. A free-running counter climbs toward a programmable limit. When it gets there, the block raises a reset request for one cycle. To prevent that, software must write the key pair to the service register: first 0x55, then 0xAA. The counter then goes back to zero.

A configuration register holds two bits, and each bit accepts only the first write after reset:

- The clock bit chooses how the counter advances. It can step on every bus clock, or only on the cycles where an external slow-tick enable is high.
- The window bit turns on a stricter mode. In that mode the key is accepted only in the last quarter of the period. Any write to the service register earlier than that is treated as runaway code and requests a reset at once.

A two-bit input picks one of three periods or turns the watchdog off.

Top module: `wdog_top`

## Requirements
- R1: During and after reset `rst_req` is low, and both configuration bits are 0: the counter uses the slow tick and normal (non-window) mode is active.
- R2: The configuration register is at address 0, with bit 0 as the clock bit and bit 1 as the window bit. Each bit takes the value of the first write to address 0 after reset. Later writes leave it unchanged until the next reset.
- R3: With the clock bit at 0 the counter advances only on cycles where `slow_tick` is 1. With the clock bit at 1 it advances on every clock.
- R4: `tmo_sel` chooses the period: 1 gives 32 ticks, 2 gives 256 and 3 gives 8192. The value 0 holds the counter at zero and never requests a reset.
- R5: When the count reaches the selected period, `rst_req` is high for exactly one cycle and counting restarts from zero. The next request therefore comes one full period later.
- R6: The service register is at address 1. In normal mode, writing 0x55 and then 0xAA to it clears the count at any time.
- R7: Any other write to the service register between the 0x55 and the 0xAA breaks the key, so the following 0xAA does not clear the count.
- R8: In window mode the key is accepted when the count (the value before the write) is at least the period minus one quarter of it. For the 32-tick period that threshold is 24.
- R9: In window mode, any write to the service register while the count is below that threshold raises `rst_req` on the next clock edge and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 configuration, 1 service) |
| wr_data | input | 8 | Write data |
| slow_tick | input | 1 | Slow tick enable used when the clock bit is 0 |
| tmo_sel | input | 2 | Period select, 0 disables |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench targets the window threshold from both sides: a write at count 23 and a key write at count 24.

- If the comparison is off by one, either a valid service triggers a reset, or an early write slips through and the period measures short.
- A broken key (0x55, a stray byte, then 0xAA) must not clear the count. A detector that only looks for 0xAA would shift the next timeout later.
- Second writes to the configuration register try to flip both bits. If a bit is not properly locked, the counting rate or the window behaviour changes, and the next timeout arrives at a different point.
- Each period length is measured exactly. A single extra register in the counter path would move every timeout by one cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // configuration held by the write-once register
    typedef struct packed {
        logic window;   // bit 1: windowed service
        logic clk_bus;  // bit 0: count on every bus clock
    } wd_cfg_t;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_bits,
    output wd_cfg_t    cfg
);
    typedef struct packed {
        wd_cfg_t    val;
        logic [1:0] lock;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr && !st_q.lock[0]) begin
            st_d.val.clk_bus = cfg_bits[0];
            st_d.lock[0]     = 1'b1;
        end
        if (cfg_wr && !st_q.lock[1]) begin
            st_d.val.window = cfg_bits[1];
            st_d.lock[1]    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.val;

    // R2: a locked bit never changes
    a_r2_clk_locked: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock[0] |=> $stable(st_q.val.clk_bus));
    a_r2_win_locked: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock[1] |=> $stable(st_q.val.window));
endmodule

// File: rtl/wdog_svc.sv
module wdog_svc
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       svc_ok
);
    typedef struct packed {
        logic armed;
    } svc_st_t;

    svc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (svc_wr) st_d.armed = (svc_data == KEY_ARM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign svc_ok = svc_wr && st_q.armed && (svc_data == KEY_FIRE);

    // R6: the first key byte arms the detector
    a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_data == KEY_ARM) |=> st_q.armed);
    // R7: any other byte disarms it
    a_r7_break: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_data != KEY_ARM) |=> !st_q.armed);
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int SH1 = 5,
    parameter int SH2 = 8,
    parameter int SH3 = 13,
    localparam int CNT_W = SH3 + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] tmo_sel,
    input  logic       window,
    input  logic       svc_wr,
    input  logic       svc_ok,
    output logic       rst_req
);
    localparam logic [CNT_W-1:0] PER1 = CNT_W'(1) << SH1;
    localparam logic [CNT_W-1:0] PER2 = CNT_W'(1) << SH2;
    localparam logic [CNT_W-1:0] PER3 = CNT_W'(1) << SH3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] cnt_inc;
    logic             en;
    logic             early;

    always_comb begin
        unique case (tmo_sel)
            2'd1:    per = PER1;
            2'd2:    per = PER2;
            2'd3:    per = PER3;
            default: per = '0;
        endcase
    end

    assign en      = (tmo_sel != 2'd0);
    assign win_lo  = per - (per >> 2);
    assign cnt_inc = st_q.cnt + 1'b1;
    assign early   = window && (st_q.cnt < win_lo);

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (svc_wr && early) begin
            st_d.req = 1'b1;
            st_d.cnt = '0;
        end else if (svc_ok) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= per) begin
                st_d.req = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.req;

    // R4: disabled watchdog stays quiet
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel == 2'd0) |=> !st_q.req);
    // R5: a request always comes with a restarted count
    a_r5_req_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (st_q.cnt == '0));
    // R9: early service write in window mode forces a request
    a_r9_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (en && svc_wr && window && st_q.cnt < win_lo) |=> st_q.req);
    // R8: in-window key clears without a request
    a_r8_window_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (en && svc_ok && window && st_q.cnt >= win_lo) |=> (!st_q.req && st_q.cnt == '0));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CFG_ADDR = 0,
    parameter int SVC_ADDR = 1,
    parameter int SH1      = 5,
    parameter int SH2      = 8,
    parameter int SH3      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              slow_tick,
    input  logic [1:0]        tmo_sel,
    output logic              rst_req
);
    wd_cfg_t cfg;
    logic    cfg_wr;
    logic    svc_wr;
    logic    svc_ok;
    logic    tick;

    assign cfg_wr = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
    assign svc_wr = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
    assign tick   = cfg.clk_bus ? 1'b1 : slow_tick;

    wdog_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_bits (wr_data[1:0]),
        .cfg      (cfg)
    );

    wdog_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (wr_data),
        .svc_ok   (svc_ok)
    );

    wdog_cnt #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tmo_sel (tmo_sel),
        .window  (cfg.window),
        .svc_wr  (svc_wr),
        .svc_ok  (svc_ok),
        .rst_req (rst_req)
    );
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       slow_tick = 1'b0;
    logic [1:0] tmo_sel = 2'd1;
    logic       rst_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    wdog_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slow_tick(slow_tick), .tmo_sel(tmo_sel),
        .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; slow_tick = 1'b0; tmo_sel = sel;
        repeat (3) @(posedge clk);
        #1 chk(rst_req == 1'b0, "R1 req low in reset", rst_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // count posedges until rst_req is seen; -1 if none within lim
    task automatic measure(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(posedge clk); #1;
            n++;
            if (rst_req) break;
        end
        if (!rst_req) n = -1;
    endtask

    task automatic t_reset();
        int n;
        do_reset(2'd1);
        measure(120, n);
        chk(n == -1, "R1 default slow clock, no tick no timeout", n, -1);
    endtask

    task automatic t_normal();
        int n;
        do_reset(2'd1);
        wr(2'd0, 8'h01);
        measure(100, n);
        measure(100, n);
        chk(n == 32, "R5 period after request", n, 32);
        idle(1);
        chk(rst_req == 1'b0, "R5 request lasts one cycle", rst_req, 0);
        measure(100, n);
        idle(10); wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
        measure(100, n);
        chk(n == 32, "R6 key restarts count", n, 32);
        idle(10); wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA);
        measure(100, n);
        chk(n == 19, "R7 broken key ignored", n, 19);
    endtask

    task automatic t_slow();
        int n;
        do_reset(2'd1);
        wr(2'd0, 8'h00);
        measure(200, n);
        chk(n == -1, "R3 slow clock holds without tick", n, -1);
        slow_tick = 1'b1;
        measure(100, n);
        chk(n == 32, "R3 slow tick advances count", n, 32);
        wr(2'd0, 8'h01);
        slow_tick = 1'b0;
        measure(200, n);
        chk(n == -1, "R2 clock bit stays 0 after rewrite", n, -1);
    endtask

    task automatic t_lock_bus();
        int n;
        do_reset(2'd1);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h02);
        measure(100, n);
        chk(n != -1, "R2 clock bit stays 1 after rewrite", n, 1);
        idle(2); wr(2'd1, 8'h55);
        chk(rst_req == 1'b0, "R2 window bit stays 0 after rewrite", rst_req, 0);
        wr(2'd1, 8'hAA);
        measure(100, n);
        chk(n == 32, "R2 normal mode key accepted early", n, 32);
    endtask

    task automatic t_window();
        int n;
        do_reset(2'd1);
        wr(2'd0, 8'h03);
        measure(100, n);
        idle(5); wr(2'd1, 8'h55);
        chk(rst_req == 1'b1, "R9 early write requests reset", rst_req, 1);
        idle(23); wr(2'd1, 8'h55);
        chk(rst_req == 1'b1, "R9 write at count 23 requests reset", rst_req, 1);
        idle(24); wr(2'd1, 8'h55);
        chk(rst_req == 1'b0, "R8 write at count 24 accepted", rst_req, 0);
        wr(2'd1, 8'hAA);
        chk(rst_req == 1'b0, "R8 key completion no request", rst_req, 0);
        measure(100, n);
        chk(n == 32, "R8 in-window key restarts count", n, 32);
    endtask

    task automatic t_sel();
        int n;
        do_reset(2'd0);
        wr(2'd0, 8'h01);
        measure(300, n);
        chk(n == -1, "R4 select 0 disables", n, -1);
        tmo_sel = 2'd2;
        measure(400, n);
        chk(n == 256, "R4 select 2 period", n, 256);
        tmo_sel = 2'd3;
        measure(9000, n);
        chk(n == 8192, "R4 select 3 period", n, 8192);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_slow();
        t_lock_bus();
        t_window();
        t_sel();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule